// File: doc/BRIEF.md
# Clearable Modulo-4 Counter With Terminal Flag

This block is a two-bit synchronous counter held in D-type registers. On every rising clock edge it either advances by one through four states, wrapping from the last state back to the first, or, when the clear input is high, returns to the first state no matter where it was. Clearing takes priority over counting.

A one-bit flag marks the terminal state. The flag depends on the current state alone, so it is a Moore-style output and the clear input has no same-cycle effect on it. A synchronous reset puts the counter back in its first state. The state is also visible at the ports, so the counter can drive a small phase sequencer and also report when the last phase is reached.

Top module: `clrcnt_mod4`

## Requirements
- R1: While rst is 1 at a rising clock edge, the state becomes 00 at that edge and term_o reads 0 afterwards.
- R2: With clr_i = 0 and rst = 0, each edge advances state_o in the order 00, 01, 10, 11, and then back to 00.
- R3: With clr_i = 1 and rst = 0, the next state is 00 from each of the four states.
- R4: term_o is 1 exactly while state_o is 11, whatever the value of clr_i, and it never stays high for two cycles in a row.
- R5: Starting from 00, the clear inputs 0, 1, 0, 0, 0 on five successive edges give the states 01, 00, 01, 10 and 11, with term_o high only after the last edge.
- R6: In state 11 with clr_i = 1, term_o stays 1 for that cycle and the state becomes 00 at the next edge.
- R7: rst takes priority over counting. With rst = 1 and clr_i = 0 in any state, the next state is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads state 00 |
| clr_i | input | 1 | Synchronous clear: 1 forces the next state to 00, 0 lets the counter advance |
| state_o | output | 2 | Current count state (00, 01, 10, 11) |
| term_o | output | 1 | High while the state is 11 |

## Verification
In one cycle the terminal flag and a clear can both be active. This happens when the counter sits in state 11 and clr_i goes high. The bench brings the counter to 11 and raises clr_i at the start of that cycle. It then checks that term_o still reads 1 before the edge, and that after the edge the state is 00 and term_o is 0. The bench compares every cycle against a state-table model, including clears from each of the four states and a reset that arrives mid-count.

// File: rtl/clrcnt_pkg.sv
package clrcnt_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_ZERO = 2'b00,
        ST_ONE  = 2'b01,
        ST_TWO  = 2'b10,
        ST_TERM = 2'b11
    } cnt_state_e;

    typedef struct packed {
        cnt_state_e state;
    } cnt_regs_t;

endpackage

// File: rtl/clrcnt_next.sv
module clrcnt_next
    import clrcnt_pkg::*;
(
    input  cnt_state_e cur_state,
    input  logic       clr,
    output cnt_state_e nxt_state
);

    logic bit0_d;
    logic bit1_d;

    // Per-bit D inputs taken from the state table
    always_comb begin
        bit0_d    = ~clr & ~cur_state[0];
        bit1_d    = ~clr & (cur_state[0] ^ cur_state[1]);
        nxt_state = cnt_state_e'({bit1_d, bit0_d});
    end

endmodule

// File: rtl/clrcnt_decode.sv
module clrcnt_decode
    import clrcnt_pkg::*;
(
    input  cnt_state_e cur_state,
    output logic       term
);

    // The flag depends on the state only
    always_comb begin
        term = cur_state[1] & cur_state[0];
    end

endmodule

// File: rtl/clrcnt_mod4.sv
module clrcnt_mod4
    import clrcnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    output logic [STATE_W-1:0] state_o,
    output logic               term_o
);

    cnt_regs_t  regs_d;
    cnt_regs_t  regs_q;
    cnt_state_e nxt_state;
    logic       term_flag;

    clrcnt_next i_next (
        .cur_state (regs_q.state),
        .clr       (clr_i),
        .nxt_state (nxt_state)
    );

    clrcnt_decode i_decode (
        .cur_state (regs_q.state),
        .term      (term_flag)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = nxt_state;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '{state: ST_ZERO};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o = regs_q.state;
    assign term_o  = term_flag;

    // R1
    reset_load_chk: assert property (@(posedge clk)
        rst |=> (state_o == 2'b00 && !term_o));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (state_o == $past(state_o) + 2'd1));

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (state_o == 2'b00));

    // R4
    term_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(term_o) |-> ($past(state_o) == 2'b10 && !$past(clr_i)));

    // R4
    term_single_chk: assert property (@(posedge clk) disable iff (rst)
        term_o |=> !term_o);

endmodule

// File: tb/test_clrcnt_mod4.sv
module test_clrcnt_mod4;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr_i = 1'b0;
    logic [1:0] state_o;
    logic       term_o;

    logic [1:0] exp_s = 2'b00;
    int         n_total = 0;
    int         n_fail  = 0;

    clrcnt_mod4 i_clrcnt_mod4 (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (clr_i),
        .state_o (state_o),
        .term_o  (term_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [1:0] es, input logic ey);
        n_total++;
        if (state_o !== es || term_o !== ey) begin
            n_fail++;
            $display("FAIL %s: state=%b term=%b expected state=%b term=%b",
                     tag, state_o, term_o, es, ey);
        end
    endtask

    // Inputs are driven and outputs sampled on the falling edge
    task automatic step(input logic x, input logic r, input string tag);
        clr_i = x;
        rst   = r;
        @(posedge clk);
        exp_s = (r || x) ? 2'b00 : exp_s + 2'd1;
        @(negedge clk);
        check(tag, exp_s, exp_s == 2'b11);
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        clr_i = 1'b0;
        @(posedge clk);
        exp_s = 2'b00;
        @(negedge clk);
        check("R1 reset", 2'b00, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_count_wrap();
        do_reset();
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, "R2 count");
        check("R2 wrap twice", 2'b00, 1'b0);
    endtask

    task automatic t_clear_each();
        for (int k = 0; k < 4; k++) begin
            do_reset();
            for (int j = 0; j < k; j++) step(1'b0, 1'b0, "R2 advance");
            step(1'b1, 1'b0, "R3 clear");
        end
        step(1'b1, 1'b0, "R3 clear held");
    endtask

    task automatic t_trace();
        do_reset();
        step(1'b0, 1'b0, "R5 t1");
        step(1'b1, 1'b0, "R5 t2");
        step(1'b0, 1'b0, "R5 t3");
        step(1'b0, 1'b0, "R5 t4");
        step(1'b0, 1'b0, "R5 t5");
        check("R5 end", 2'b11, 1'b1);
    endtask

    task automatic t_term_clear();
        do_reset();
        for (int j = 0; j < 3; j++) step(1'b0, 1'b0, "R4 to term");
        clr_i = 1'b1;
        #1;
        check("R6 flag with clear", 2'b11, 1'b1);
        check("R4 flag ignores x", 2'b11, 1'b1);
        step(1'b1, 1'b0, "R6 after clear");
        check("R4 flag low", 2'b00, 1'b0);
    endtask

    task automatic t_reset_mid();
        do_reset();
        step(1'b0, 1'b0, "R2 to one");
        step(1'b0, 1'b0, "R2 to two");
        step(1'b0, 1'b1, "R7 reset wins");
        step(1'b0, 1'b0, "R7 resume");
        for (int j = 0; j < 2; j++) step(1'b0, 1'b0, "R2 resume");
        step(1'b0, 1'b1, "R7 reset in term");
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_count_wrap();
        t_clear_each();
        t_trace();
        t_term_clear();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule